// File: doc/BRIEF.md
# Double-Precision Compare Mask Unit

This block compares two 64-bit IEEE 754 double operands under one of four predicates: equal, not equal, less than, and less or equal. Each qualified input pair produces a registered outcome one cycle later. The outcome takes two forms. The first is a 64-bit word that is all ones when the predicate holds and all zeros when it does not, so consumers can use it directly as a bit mask or test its sign bit. The second is a single true/false bit.

In vector mode, the same outcome is also written into one bit of a 64-bit element mask, at the position given by the element index. A start-of-vector strobe clears that mask. Subnormal operands are flushed to a zero of the same sign before the compare. The unit also reports an invalid-operation flag, which a sticky status register elsewhere can collect.

Top module: `dcmp_mask`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_valid` is high for exactly one cycle, and `result` is all ones (`cmp_true`=1) when the predicate holds or all zeros (`cmp_true`=0) when it does not. Without `in_valid`, `out_valid` is low in the next cycle.
- R2: Predicate codes on `pred` are 2'b00 EQ, 2'b01 NE, 2'b10 LT (a<b) and 2'b11 LE (a<=b), evaluated on ordered finite values by their numeric value.
- R3: +0 and -0 compare equal, so -0 LT +0 is false and -0 LE +0 is true.
- R4: An operand with exponent field zero and a nonzero fraction is treated as a zero of its own sign. Such an operand equals either zero and equals any other subnormal.
- R5: An operand with exponent all ones and a nonzero fraction is a NaN. Any compare involving a NaN is unordered: EQ, LT and LE are false and NE is true.
- R6: `flag_invalid` is registered with the outcome. It is 1 when either operand is a signaling NaN (fraction bit 51 = 0), for every predicate. It is also 1 when either operand is a quiet NaN (fraction bit 51 = 1) and the predicate is LT or LE. In all other cases it is 0.
- R7: When `vec_mode` is high with `in_valid`, bit `elem_idx` of `mask` takes the outcome one cycle later, and every other mask bit keeps its value.
- R8: `vec_start` clears `mask` to zero on the next cycle. When `vec_start` coincides with a valid vector compare, only that element's bit can be set afterwards.
- R9: A compare with `vec_mode` low leaves `mask` unchanged.
- R10: Infinities (exponent all ones, fraction zero) are ordered: -inf is below every finite value, +inf is above every finite value, and each infinity equals itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair and predicate are valid this cycle |
| op_a | input | 64 | Left operand, IEEE double |
| op_b | input | 64 | Right operand, IEEE double |
| pred | input | 2 | Predicate code |
| vec_mode | input | 1 | Write the outcome into the element mask |
| elem_idx | input | 6 | Element position in the mask |
| vec_start | input | 1 | Clear the element mask |
| out_valid | output | 1 | Registered outcome is valid |
| result | output | 64 | All-ones or all-zeros outcome word |
| cmp_true | output | 1 | Outcome as a single bit |
| flag_invalid | output | 1 | Invalid-operation flag for this outcome |
| mask | output | 64 | Per-element compare mask |

## Verification
The hardest situation to reach from the ports is the mix of partial mask updates: a strobe that coincides with a valid element write, and a later write that clears an already set bit while its neighbours must survive. The stimulus builds a known pattern across elements 0, 5 and 63. It then overwrites element 0 with a false outcome, issues a scalar compare in between, and reads the whole mask after each step. The NaN cases pair each NaN kind with all four predicates, so that the predicate dependence of the invalid flag is exercised in both directions.

// File: rtl/dcmp_mask.sv
module dcmp_mask #(
  parameter int W     = 64,
  parameter int EXPW  = 11,
  parameter int MASKN = 64,
  localparam int FRACW = W - EXPW - 1,
  localparam int IDXW  = $clog2(MASKN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [1:0]      pred,
  input  logic            vec_mode,
  input  logic [IDXW-1:0] elem_idx,
  input  logic            vec_start,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            cmp_true,
  output logic            flag_invalid,
  output logic [MASKN-1:0] mask
);

  logic [EXPW-1:0]  ea, eb;
  logic [FRACW-1:0] fa, fb;
  logic             sa, sb;
  assign sa = op_a[W-1];
  assign sb = op_b[W-1];
  assign ea = op_a[W-2:FRACW];
  assign eb = op_b[W-2:FRACW];
  assign fa = op_a[FRACW-1:0];
  assign fb = op_b[FRACW-1:0];

  logic a_nan, b_nan, a_snan, b_snan, a_zero, b_zero;
  assign a_nan  = (&ea) && (|fa);
  assign b_nan  = (&eb) && (|fb);
  assign a_snan = a_nan && !fa[FRACW-1];
  assign b_snan = b_nan && !fb[FRACW-1];
  assign a_zero = ~|ea;
  assign b_zero = ~|eb;

  logic [W-2:0] a_mag, b_mag;
  assign a_mag = a_zero ? '0 : op_a[W-2:0];
  assign b_mag = b_zero ? '0 : op_b[W-2:0];

  logic unord, both_zero, is_eq, is_lt, outcome, raise_inv;
  assign unord     = a_nan || b_nan;
  assign both_zero = a_zero && b_zero;
  assign is_eq = !unord && (both_zero || (sa == sb && a_mag == b_mag));
  assign is_lt = !unord && !both_zero &&
                 (( sa && !sb) ||
                  (!sa && !sb && a_mag < b_mag) ||
                  ( sa &&  sb && a_mag > b_mag));

  always_comb begin
    case (pred)
      2'b00:   outcome = is_eq;
      2'b01:   outcome = !is_eq;
      2'b10:   outcome = is_lt;
      default: outcome = is_lt || is_eq;
    endcase
  end

  assign raise_inv = a_snan || b_snan || (unord && pred[1]);

  logic [MASKN-1:0] mask_nxt;
  always_comb begin
    mask_nxt = vec_start ? '0 : mask;
    if (in_valid && vec_mode) mask_nxt[elem_idx] = outcome;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      result       <= '0;
      cmp_true     <= 1'b0;
      flag_invalid <= 1'b0;
      mask         <= '0;
    end else begin
      out_valid    <= in_valid;
      mask         <= mask_nxt;
      if (in_valid) begin
        result       <= {W{outcome}};
        cmp_true     <= outcome;
        flag_invalid <= raise_inv;
      end else begin
        flag_invalid <= 1'b0;
      end
    end
  end

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_word_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result == {W{cmp_true}}));
  p_unordered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unord && pred != 2'b01) |=> !cmp_true);
  p_snan_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_snan || b_snan)) |=> flag_invalid);
  p_zero_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_zero && pred == 2'b00) |=> cmp_true);
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_start && !(in_valid && vec_mode)) |=> (mask == '0));
  p_scalar_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_start && !(in_valid && vec_mode)) |=> $stable(mask));

endmodule

// File: tb/dcmp_mask_tb.sv
module dcmp_mask_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] M1   = 64'hBFF0000000000000;
  localparam logic [63:0] M2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] MZ   = 64'h8000000000000000;
  localparam logic [63:0] PSUB = 64'h0000000000000001;
  localparam logic [63:0] MSUB = 64'h800FFFFFFFFFFFFF;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] MINF = 64'hFFF0000000000000;
  localparam logic [63:0] BIG  = 64'h7FEFFFFFFFFFFFFF;

  logic clk = 0, rst_n = 0, in_valid = 0, vec_mode = 0, vec_start = 0;
  logic [63:0] op_a = 0, op_b = 0;
  logic [1:0] pred = 0;
  logic [5:0] elem_idx = 0;
  logic out_valid, cmp_true, flag_invalid;
  logic [63:0] result, mask;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcmp_mask dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .pred(pred), .vec_mode(vec_mode), .elem_idx(elem_idx),
    .vec_start(vec_start), .out_valid(out_valid), .result(result),
    .cmp_true(cmp_true), .flag_invalid(flag_invalid), .mask(mask));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [1:0] p,
                       logic vm, logic [5:0] idx, logic vs, logic v);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; vec_mode = vm; elem_idx = idx;
    vec_start = vs; in_valid = v;
    @(posedge clk); #1;
    @(negedge clk);
    in_valid = 0; vec_start = 0; vec_mode = 0;
  endtask

  task automatic sample(logic [63:0] a, logic [63:0] b, logic [1:0] p,
                        logic vm, logic [5:0] idx, logic vs);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; vec_mode = vm; elem_idx = idx;
    vec_start = vs; in_valid = 1;
    @(posedge clk); #1;
  endtask

  task automatic cmp(string tag, logic [63:0] a, logic [63:0] b,
                     logic [1:0] p, logic exp_t, logic exp_inv);
    sample(a, b, p, 1'b0, 6'd0, 1'b0);
    check({tag, " out_valid"}, {63'b0, out_valid}, 64'd1);
    check({tag, " result"}, result, {64{exp_t}});
    check({tag, " cmp_true"}, {63'b0, cmp_true}, {63'b0, exp_t});
    check({tag, " flag_invalid"}, {63'b0, flag_invalid}, {63'b0, exp_inv});
    @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    check("R1 reset out_valid", {63'b0, out_valid}, 64'd0);
    check("R7 reset mask", mask, 64'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 idle out_valid", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_ordered;
    cmp("R2 EQ 1==1", P1, P1, 2'b00, 1, 0);
    cmp("R2 EQ 1==2", P1, P2, 2'b00, 0, 0);
    cmp("R2 NE 1!=2", P1, P2, 2'b01, 1, 0);
    cmp("R2 LT 1<2", P1, P2, 2'b10, 1, 0);
    cmp("R2 LT 2<1", P2, P1, 2'b10, 0, 0);
    cmp("R2 LT -2<-1", M2, M1, 2'b10, 1, 0);
    cmp("R2 LT -1<-2", M1, M2, 2'b10, 0, 0);
    cmp("R2 LT -1<1", M1, P1, 2'b10, 1, 0);
    cmp("R2 LE 1<=1", P1, P1, 2'b11, 1, 0);
    cmp("R2 LE 2<=1", P2, P1, 2'b11, 0, 0);
    @(posedge clk); #1;
    check("R1 pulse ends", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_zeros;
    cmp("R3 EQ -0==+0", MZ, PZ, 2'b00, 1, 0);
    cmp("R3 LT -0<+0", MZ, PZ, 2'b10, 0, 0);
    cmp("R3 LE -0<=+0", MZ, PZ, 2'b11, 1, 0);
    cmp("R3 NE +0!=-0", PZ, MZ, 2'b01, 0, 0);
  endtask

  task automatic t_subnormal;
    cmp("R4 EQ sub==+0", PSUB, PZ, 2'b00, 1, 0);
    cmp("R4 EQ -sub==+sub", MSUB, PSUB, 2'b00, 1, 0);
    cmp("R4 LT -sub<+sub", MSUB, PSUB, 2'b10, 0, 0);
    cmp("R4 LT sub<1", PSUB, P1, 2'b10, 1, 0);
  endtask

  task automatic t_nan;
    cmp("R5 EQ qnan", QNAN, QNAN, 2'b00, 0, 0);
    cmp("R5 NE qnan", P1, QNAN, 2'b01, 1, 0);
    cmp("R5 LT qnan", QNAN, P1, 2'b10, 0, 1);
    cmp("R5 LE qnan", P1, QNAN, 2'b11, 0, 1);
    cmp("R6 EQ snan", SNAN, P1, 2'b00, 0, 1);
    cmp("R6 NE snan", P1, SNAN, 2'b01, 1, 1);
    cmp("R6 LT snan", SNAN, P1, 2'b10, 0, 1);
    cmp("R6 LE snan inf", PINF, SNAN, 2'b11, 0, 1);
  endtask

  task automatic t_inf;
    cmp("R10 LT -inf<-big", MINF, {1'b1, BIG[62:0]}, 2'b10, 1, 0);
    cmp("R10 LT big<inf", BIG, PINF, 2'b10, 1, 0);
    cmp("R10 LT inf<big", PINF, BIG, 2'b10, 0, 0);
    cmp("R10 EQ inf==inf", PINF, PINF, 2'b00, 1, 0);
    cmp("R10 EQ -inf==inf", MINF, PINF, 2'b00, 0, 0);
  endtask

  task automatic t_vector;
    drive(P1, P2, 2'b10, 1, 6'd63, 1'b0, 1);
    drive(P1, P1, 2'b00, 1, 6'd0, 1'b1, 1);
    check("R8 start with write", mask, 64'h0000000000000001);
    drive(P2, P1, 2'b10, 1, 6'd5, 1'b0, 1);
    check("R7 false elem 5", mask, 64'h0000000000000001);
    drive(M1, P1, 2'b11, 1, 6'd63, 1'b0, 1);
    check("R7 elem 63", mask, 64'h8000000000000001);
    drive(P1, P1, 2'b01, 1, 6'd5, 1'b0, 1);
    check("R7 elem 5 NE false", mask, 64'h8000000000000001);
    drive(P1, P1, 2'b00, 0, 6'd1, 1'b0, 1);
    check("R9 scalar keeps mask", mask, 64'h8000000000000001);
    drive(P1, P2, 2'b00, 1, 6'd0, 1'b0, 1);
    check("R7 clear elem 0", mask, 64'h8000000000000000);
    drive(QNAN, P1, 2'b01, 1, 6'd7, 1'b0, 1);
    check("R7 nan NE elem 7", mask, 64'h8000000000000080);
    drive(P1, P1, 2'b00, 0, 6'd0, 1'b1, 0);
    check("R8 strobe clears", mask, 64'd0);
  endtask

  initial begin
    t_reset;
    t_ordered;
    t_zeros;
    t_subnormal;
    t_nan;
    t_inf;
    t_vector;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule